// File: doc/BRIEF.md
# Micro-packet transport stream reassembler

This block rebuilds 188-byte transport stream packets from a stream of 32-bit capture words. Each word names one of four channels, may mark the start of a packet, and carries up to three payload bytes. Every channel has its own fragment counter and its own 188-byte assembly buffer. A completed packet is queued for that channel and then leaves on a byte-wide valid/ready output, with its channel number and first/last markers.

Words are taken from a capture page. The page may be read only while its final word (presented on `tail_word`) is nonzero. Once a full page of words has been accepted, the block pulses `tail_clr` so that the supplier can zero that final word and refill the page. Channels are switched on and off through a masked enable write.

Back-pressure rules: a word is transferred on a cycle where `in_valid` and `in_ready` are both high. `in_ready` depends on the tag of the presented word, so a producer must hold `in_word` steady while `in_valid` is high. On the output, a byte is transferred when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and every output field hold their values. A channel whose queued packet has not fully drained stalls only its own words. Words for other channels keep flowing.

Top module: `mts_reassembler`

## Requirements
- R1: Word bits 31:29 hold the channel number plus one. A word whose field is 0 or greater than 4 is accepted and discarded, and it leaves every channel's packet untouched.
- R2: When word bit 25 (start) is set, the channel's fragment count restarts at 0 before the payload is stored. Any partial packet is abandoned and the output carries only the new packet.
- R3: A word without the start bit, arriving while its channel's fragment count is 0, is discarded.
- R4: Payload bits 23:16, 15:8 and 7:0 are stored in that order at byte offset 3×count. A packet is made of 63 fragments (counts 0..62). Fragment 62 contributes only bits 23:16 and 15:8, so every packet is exactly 188 bytes.
- R5: When `en_we` is high, each channel i whose `en_cfg[8+i]` is 1 takes `en_cfg[i]` as its enable. Channels with a 0 mask bit keep their enable. After reset every channel is disabled.
- R6: Words for a disabled channel are discarded. Disabling a channel resets its fragment count to 0, so a partial packet cannot be completed after the channel is re-enabled.
- R7: A completed packet is queued. While it is pending, a word for that enabled channel holds `in_ready` low. Words for other channels and discarded words are still accepted.
- R8: The output sends one pending packet at a time as 188 bytes. `out_chan` holds the channel number, `out_first` is high on byte 0 only and `out_last` is high on byte 187 only. The output fields are stable while `out_ready` is low.
- R9: `in_ready` is low while `tail_word` is zero. After every `PAGE_WORDS` accepted words, `tail_clr` is high for exactly one cycle, and `in_ready` is low during that cycle.
- R10: During and right after reset, `out_valid` and `tail_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture word valid |
| in_ready | output | 1 | Capture word accepted this cycle when valid |
| in_word | input | 32 | Capture word: tag 31:29, start 25, bytes 23:0 |
| tail_word | input | 32 | Final word of the current page; nonzero means the page is filled |
| tail_clr | output | 1 | One-cycle pulse: current page consumed, clear its final word |
| en_we | input | 1 | Enable write strobe |
| en_cfg | input | 12 | Enable mask in 11:8, enable values in 3:0 |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Packet byte |
| out_chan | output | 2 | Channel of the packet being sent |
| out_first | output | 1 | First byte of packet |
| out_last | output | 1 | Last byte of packet |

## Verification
The bound checker watches four things on every cycle:
- Output hold under back-pressure.
- That each packet starts with a first marker and has exactly 188 bytes up to its last marker.
- The single-cycle page-clear pulse, together with input gating while the clear is high or the page is empty.
- That a new packet never starts in the cycle right after a last byte.

Several behaviours depend on the payload and the channel bookkeeping, and only the bench scenarios show them: payload byte order, truncation of the final fragment, tag rejection, resynchronisation on a start word, discarding before the first start, masked enable writes, loss of a partial packet on disable, and the per-channel input stall.

// File: rtl/mts_pkg.sv
package mts_pkg;
  localparam int NUM_CH     = 4;
  localparam int CH_W       = 2;
  localparam int FRAG_BYTES = 3;
  localparam int TAG_HI     = 31;
  localparam int TAG_LO     = 29;
  localparam int START_BIT  = 25;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] ch;
    logic            start;
    logic [7:0]      b0;
    logic [7:0]      b1;
    logic [7:0]      b2;
  } frag_t;
endpackage

// File: rtl/mts_frag_decode.sv
module mts_frag_decode
  import mts_pkg::*;
(
  input  logic [31:0] word,
  output frag_t       frag
);
  logic [TAG_HI-TAG_LO:0] tag;

  always_comb begin
    tag        = word[TAG_HI:TAG_LO];
    frag.hit   = (tag != '0) && (int'(tag) <= NUM_CH);
    frag.ch    = CH_W'(tag - 1'b1);
    frag.start = word[START_BIT];
    frag.b0    = word[23:16];
    frag.b1    = word[15:8];
    frag.b2    = word[7:0];
  end
endmodule

// File: rtl/mts_chan_asm.sv
module mts_chan_asm
  import mts_pkg::*;
#(
  parameter int PKT_BYTES = 188,
  localparam int FRAGS    = (PKT_BYTES + FRAG_BYTES - 1) / FRAG_BYTES,
  localparam int LAST_N   = PKT_BYTES - (FRAGS - 1) * FRAG_BYTES,
  localparam int CNT_W    = $clog2(FRAGS),
  localparam int IDX_W    = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store,
  input  logic             start,
  input  logic [7:0]       b0,
  input  logic [7:0]       b1,
  input  logic [7:0]       b2,
  input  logic             set_en,
  input  logic             en_val,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_done,
  output logic             en,
  output logic             full,
  output logic [7:0]       rd_byte
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] base;
  logic             take;
  logic             last_frag;
  logic [7:0]       bytes [FRAG_BYTES];
  logic [7:0]       mem   [PKT_BYTES];

  always_comb begin
    base      = start ? '0 : cnt;
    take      = store && (start || cnt != '0);
    last_frag = (base == CNT_W'(FRAGS - 1));
    bytes[0]  = b0;
    bytes[1]  = b1;
    bytes[2]  = b2;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      for (int k = 0; k < FRAG_BYTES; k++) begin
        if (!last_frag || k < LAST_N)
          mem[IDX_W'(int'(base) * FRAG_BYTES + k)] <= bytes[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      if (rd_done) full <= 1'b0;
      if (take) begin
        cnt <= last_frag ? '0 : base + 1'b1;
        if (last_frag) full <= 1'b1;
      end
      if (set_en) begin
        en <= en_val;
        if (!en_val) cnt <= '0;
      end
    end
  end

  assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/mts_out_arb.sv
module mts_out_arb
  import mts_pkg::*;
#(
  parameter int PKT_BYTES = 188,
  localparam int IDX_W    = $clog2(PKT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] full,
  input  logic              out_ready,
  output logic              busy,
  output logic [CH_W-1:0]   sel,
  output logic [IDX_W-1:0]  idx,
  output logic [NUM_CH-1:0] done
);
  logic            fire;
  logic            at_end;
  logic [CH_W-1:0] pick;

  always_comb begin
    fire   = busy && out_ready;
    at_end = (idx == IDX_W'(PKT_BYTES - 1));
    pick   = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (full[c]) pick = CH_W'(c);
    for (int c = 0; c < NUM_CH; c++)
      done[c] = fire && at_end && (sel == CH_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sel  <= '0;
      idx  <= '0;
    end else if (!busy) begin
      if (|full) begin
        busy <= 1'b1;
        sel  <= pick;
        idx  <= '0;
      end
    end else if (fire) begin
      if (at_end) busy <= 1'b0;
      else        idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/mts_reassembler.sv
module mts_reassembler
  import mts_pkg::*;
#(
  parameter int PKT_BYTES  = 188,
  parameter int PAGE_WORDS = 1024,
  localparam int IDX_W     = $clog2(PKT_BYTES),
  localparam int WCNT_W    = $clog2(PAGE_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  input  logic [31:0] tail_word,
  output logic        tail_clr,
  input  logic        en_we,
  input  logic [11:0] en_cfg,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic [1:0]  out_chan,
  output logic        out_first,
  output logic        out_last
);
  frag_t              frag;
  logic [NUM_CH-1:0]  ch_en;
  logic [NUM_CH-1:0]  ch_full;
  logic [NUM_CH-1:0]  ch_done;
  logic [NUM_CH-1:0]  ch_store;
  logic [7:0]         ch_byte [NUM_CH];
  logic               busy;
  logic [CH_W-1:0]    sel;
  logic [IDX_W-1:0]   idx;
  logic               stall;
  logic               accept;
  logic [WCNT_W-1:0]  wcnt;

  mts_frag_decode u_dec (.word(in_word), .frag(frag));

  always_comb begin
    stall    = frag.hit && ch_en[frag.ch] && ch_full[frag.ch];
    in_ready = (tail_word != '0) && !tail_clr && !stall;
    accept   = in_valid && in_ready;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_store[c] = accept && frag.hit && (frag.ch == CH_W'(c)) && ch_en[c];
    mts_chan_asm #(.PKT_BYTES(PKT_BYTES)) u_asm (
      .clk    (clk),
      .rst_n  (rst_n),
      .store  (ch_store[c]),
      .start  (frag.start),
      .b0     (frag.b0),
      .b1     (frag.b1),
      .b2     (frag.b2),
      .set_en (en_we && en_cfg[8 + c]),
      .en_val (en_cfg[c]),
      .rd_idx (idx),
      .rd_done(ch_done[c]),
      .en     (ch_en[c]),
      .full   (ch_full[c]),
      .rd_byte(ch_byte[c])
    );
  end

  mts_out_arb #(.PKT_BYTES(PKT_BYTES)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .full     (ch_full),
    .out_ready(out_ready),
    .busy     (busy),
    .sel      (sel),
    .idx      (idx),
    .done     (ch_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt     <= '0;
      tail_clr <= 1'b0;
    end else begin
      tail_clr <= accept && (wcnt == WCNT_W'(PAGE_WORDS - 1));
      if (accept)
        wcnt <= (wcnt == WCNT_W'(PAGE_WORDS - 1)) ? '0 : wcnt + 1'b1;
    end
  end

  assign out_valid = busy;
  assign out_data  = ch_byte[sel];
  assign out_chan  = sel;
  assign out_first = busy && (idx == '0);
  assign out_last  = busy && (idx == IDX_W'(PKT_BYTES - 1));
endmodule

// File: rtl/mts_reassembler_chk.sv
module mts_reassembler_chk #(
  parameter int PKT_BYTES = 188,
  localparam int LEN_W    = $clog2(PKT_BYTES) + 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic [31:0] tail_word,
  input logic        tail_clr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic [1:0]  out_chan,
  input logic        out_first,
  input logic        out_last
);
  logic [LEN_W-1:0] nbytes;
  logic             xfer;

  assign xfer = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    nbytes <= '0;
    else if (xfer) nbytes <= out_last ? '0 : nbytes + 1'b1;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)
                                   && $stable(out_first) && $stable(out_last)));

  assert_first_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_first) |-> (nbytes == '0));

  assert_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_last) |-> (nbytes == LEN_W'(PKT_BYTES - 1)));

  assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_last) |=> !out_valid);

  assert_clr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tail_clr |=> !tail_clr);

  assert_page_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (tail_word != '0 && !tail_clr));

  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !tail_clr));
endmodule

bind mts_reassembler mts_reassembler_chk #(.PKT_BYTES(PKT_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .tail_word(tail_word),
  .tail_clr (tail_clr),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_chan (out_chan),
  .out_first(out_first),
  .out_last (out_last)
);

// File: tb/mts_reassembler_bench.sv
module mts_reassembler_bench;
  localparam int PKT   = 188;
  localparam int NFRAG = 63;
  localparam int PAGE  = 64;

  // Packet table: {channel[9:8], seed[7:0]}
  localparam logic [9:0] VEC [0:5] = '{
    {2'd0, 8'h00}, {2'd1, 8'h35}, {2'd2, 8'hA7},
    {2'd3, 8'hFE}, {2'd1, 8'h5A}, {2'd0, 8'hC3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [31:0] tail_word = '0;
  logic        tail_clr;
  logic        en_we = 1'b0;
  logic [11:0] en_cfg = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic [1:0]  out_chan;
  logic        out_first;
  logic        out_last;
  logic        auto_refill = 1'b0;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mts_reassembler #(.PKT_BYTES(PKT), .PAGE_WORDS(PAGE)) u_mts_reassembler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .tail_word(tail_word), .tail_clr(tail_clr),
    .en_we(en_we), .en_cfg(en_cfg), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_chan(out_chan), .out_first(out_first), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input int tag, input bit st,
                                      input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] c);
    return {3'(tag), 3'b000, st, 1'b0, a, b, c};
  endfunction

  function automatic logic [31:0] frag(input int ch, input logic [7:0] seed,
                                       input int i, input bit st);
    logic [7:0] c;
    c = (i == NFRAG - 1) ? 8'hEE : 8'(int'(seed) + 3 * i + 2);
    return mkw(ch + 1, st, 8'(int'(seed) + 3 * i), 8'(int'(seed) + 3 * i + 1), c);
  endfunction

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_range(input int ch, input logic [7:0] seed,
                            input int from, input int to, input bit st);
    for (int i = from; i <= to; i++) send(frag(ch, seed, i, st && i == from));
  endtask

  task automatic write_en(input logic [3:0] mask, input logic [3:0] val);
    @(negedge clk);
    en_we  = 1'b1;
    en_cfg = {mask, 4'b0000, val};
    @(negedge clk);
    en_we  = 1'b0;
  endtask

  task automatic expect_packet(input int ch, input logic [7:0] seed, input bit bp,
                               input string req);
    int got = 0;
    int bad_data = 0;
    int bad_mark = 0;
    int bad_ch = 0;
    int waited = 0;
    int first_bad = -1;
    logic [7:0] exp_b;
    while (got < PKT && waited < 4000) begin
      @(negedge clk);
      waited++;
      out_ready = bp ? ~out_ready : 1'b1;
      if (out_valid && out_ready) begin
        exp_b = 8'(int'(seed) + got);
        if (out_data !== exp_b) begin
          bad_data++;
          if (first_bad < 0) first_bad = got;
        end
        if (out_first !== (got == 0) || out_last !== (got == PKT - 1)) bad_mark++;
        if (out_chan !== 2'(ch)) bad_ch++;
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(got == PKT, {req, " byte count"}, got, PKT);
    chk(bad_data == 0, {req, " payload bytes"}, first_bad, -1);
    chk(bad_mark == 0, {"R8 first/last markers ", req}, bad_mark, 0);
    chk(bad_ch == 0, {"R8 channel tag ", req}, int'(out_chan), ch);
  endtask

  task automatic expect_silent(input int n, input string req);
    int seen = 0;
    out_ready = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    out_ready = 1'b0;
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin : refill
    forever begin
      @(negedge clk);
      if (auto_refill && tail_clr) begin
        tail_word = '0;
        @(negedge clk);
        @(negedge clk);
        tail_word = 32'h0000_0001;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid in reset", int'(out_valid), 0);
    chk(tail_clr == 1'b0, "R10 tail_clr in reset", int'(tail_clr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R9 ready low on empty page", int'(in_ready), 0);

    // R9: page consumption and clear pulse
    tail_word = 32'h8000_0000;
    for (int i = 0; i < PAGE; i++) send(mkw(0, 1'b0, 8'h11, 8'h22, 8'h33));
    #1;
    chk(tail_clr == 1'b1, "R9 clear pulse after page", int'(tail_clr), 1);
    chk(in_ready == 1'b0, "R9 ready low during clear", int'(in_ready), 0);
    @(negedge clk);
    chk(tail_clr == 1'b0, "R9 clear is one cycle", int'(tail_clr), 0);
    tail_word = '0;
    #1;
    chk(in_ready == 1'b0, "R9 ready low after tail cleared", int'(in_ready), 0);
    tail_word = 32'h1;
    auto_refill = 1'b1;

    // R5: all channels off after reset
    send_range(2, 8'h40, 0, NFRAG - 1, 1'b1);
    expect_silent(300, "R5 disabled after reset drops packet");

    // R5: masked write enables only channel 0
    write_en(4'b0001, 4'b1111);
    send_range(1, 8'h50, 0, NFRAG - 1, 1'b1);
    expect_silent(300, "R5 unmasked channel stays off");
    send_range(0, 8'h60, 0, NFRAG - 1, 1'b1);
    expect_packet(0, 8'h60, 1'b0, "R5 masked channel on");

    write_en(4'b1111, 4'b1111);

    // R4/R8: table of packets
    for (int v = 0; v < 6; v++) begin
      send_range(int'(VEC[v][9:8]), VEC[v][7:0], 0, NFRAG - 1, 1'b1);
      expect_packet(int'(VEC[v][9:8]), VEC[v][7:0], v[0], "R4 table packet");
    end

    // R1: foreign tags mixed in
    for (int i = 0; i < NFRAG; i++) begin
      send(frag(3, 8'h21, i, i == 0));
      if (i % 7 == 3) send(mkw(0, 1'b1, 8'hAA, 8'hAA, 8'hAA));
      if (i % 11 == 5) send(mkw(5, 1'b1, 8'hBB, 8'hBB, 8'hBB));
      if (i % 13 == 8) send(mkw(7, 1'b0, 8'hCC, 8'hCC, 8'hCC));
    end
    expect_packet(3, 8'h21, 1'b0, "R1 bad tags ignored");

    // R3: words before the first start are dropped
    send_range(1, 8'h90, 5, 9, 1'b0);
    send_range(1, 8'h77, 0, NFRAG - 1, 1'b1);
    expect_packet(1, 8'h77, 1'b0, "R3 pre-start words dropped");

    // R2: resync on a new start flag
    send_range(2, 8'h10, 0, 19, 1'b1);
    send_range(2, 8'h80, 0, NFRAG - 1, 1'b1);
    expect_packet(2, 8'h80, 1'b1, "R2 resync on start");

    // R8: interleaved channels leave one whole packet at a time
    for (int i = 0; i < NFRAG; i++) begin
      send(frag(1, 8'h0F, i, i == 0));
      send(frag(3, 8'hF0, i, i == 0));
    end
    expect_packet(1, 8'h0F, 1'b0, "R8 interleave first");
    expect_packet(3, 8'hF0, 1'b1, "R8 interleave second");

    // R7: per-channel stall while a packet is queued
    send_range(0, 8'h33, 0, NFRAG - 1, 1'b1);
    repeat (4) @(negedge clk);
    in_word = frag(0, 8'h00, 0, 1'b1);
    #1;
    chk(in_ready == 1'b0, "R7 stall own channel", int'(in_ready), 0);
    in_word = frag(1, 8'h00, 0, 1'b1);
    #1;
    chk(in_ready == 1'b1, "R7 other channel flows", int'(in_ready), 1);
    in_word = mkw(0, 1'b0, 8'h0, 8'h0, 8'h0);
    #1;
    chk(in_ready == 1'b1, "R7 dropped word flows", int'(in_ready), 1);
    expect_packet(0, 8'h33, 1'b0, "R7 queued packet");
    in_word = frag(0, 8'h00, 0, 1'b1);
    #1;
    chk(in_ready == 1'b1, "R7 stall released", int'(in_ready), 1);

    // R6: disabling mid-packet loses the partial packet
    send_range(0, 8'h44, 0, 29, 1'b1);
    write_en(4'b0001, 4'b0000);
    send_range(0, 8'h44, 30, 34, 1'b0);
    write_en(4'b0001, 4'b0001);
    send_range(0, 8'h44, 30, NFRAG - 1, 1'b0);
    expect_silent(300, "R6 partial packet lost on disable");
    send_range(0, 8'h99, 0, NFRAG - 1, 1'b1);
    expect_packet(0, 8'h99, 1'b1, "R6 channel usable after re-enable");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule